// File: doc/BRIEF.md
# Cascadable Shift-Add Multiply/Divide Engine

This block is a sequential unsigned arithmetic engine built around three operand registers, X, Y and Z. Their working width is 8N bits, where the unit count N (1 to 4, capped by the `MAX_UNITS` parameter) is chosen at run time through the control word. A multiply forms the product of X and Z by add and shift right, and adds the earlier contents of Y to it. A divide uses restoring subtract and shift left, splitting the dividend held in Y:Z by X. The quotient goes to Z and the remainder to Y.

The host loads operands through parallel load strobes. It then writes the control word, which selects the operation, the unit count, optional clears of Y and Z, and a shift prescaler. Every operation runs a fixed burst of 8N+1 shift pulses. `busy` stays high for the whole burst, and `done` pulses once when the burst ends. Status bit 0 holds an overflow flag that is captured on each control write and has meaning only for a divide. Control and status pins are plain levels and strobes. No operand stream crosses the edge of the block, so it has no valid/ready handshake.

Control word layout: bit 7 enables the prescaler, bit 6 has no function, bits 5:4 hold the unit code, bit 3 clears Y, bit 2 clears Z, and bits 1:0 hold the operation.

Top module: `mdu_engine`

## Requirements
- R1: With operation code 01, the engine leaves Y:Z = X*Z + Y, taken over the low 8N bits of each register. Y holds the upper 8N bits of the 16N-bit result. X is unchanged at all 32 bits.
- R2: With operation code 10 and Y < X over 8N bits, the engine leaves Z = (Y:Z) / X and Y = (Y:Z) mod X. X is unchanged.
- R3: On every accepted control write, status bit 0 is set to 1 if the low 8N bits of Y (taken as zero when bit 3 is set) are greater than or equal to the low 8N bits of X, and to 0 otherwise. This includes a zero divisor. Status bits 7:1 always read 0.
- R4: Operation code 00 (none) and code 11 (illegal) start nothing. `busy` stays low and `done` stays low.
- R5: Control bits 5:4 select N: 11 gives N=1, 10 gives N=2, 01 gives N=3 and 00 gives N=4. When an operation starts, the bits of Y and Z above 8N are cleared.
- R6: On an accepted control write, bit 3 clears Y and bit 2 clears Z before any operation begins. This also applies with operation code 00.
- R7: `busy` is high for exactly (8N+1)*R clock cycles after the control write. `done` is then a single-cycle pulse in the first cycle with `busy` low.
- R8: The prescale ratio R is 1 when control bit 7 is 0. When bit 7 is 1, R is 2 for N=1, 4 for N=2, and 8 for N=3 or N=4.
- R9: Register loads and control writes made while `busy` is high have no effect on the registers, the status or the running operation.
- R10: After reset, `busy` is 0, `done` is 0, the status is 0, X, Y and Z read 0, and the operation is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low clear |
| ld_x | input | 1 | Load X from ld_data (ignored while busy) |
| ld_y | input | 1 | Load Y from ld_data (ignored while busy) |
| ld_z | input | 1 | Load Z from ld_data (ignored while busy) |
| ld_data | input | 8*MAX_UNITS | Operand load value |
| ctl_we | input | 1 | Control word write strobe |
| ctl_data | input | 8 | Control word |
| x_q | output | 8*MAX_UNITS | X register |
| y_q | output | 8*MAX_UNITS | Y register (upper half / remainder) |
| z_q | output | 8*MAX_UNITS | Z register (lower half / quotient) |
| status | output | 8 | Bit 0: overflow; bits 7:1 zero |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with the default `MAX_UNITS` = 4, giving 32-bit registers. With that build, all four run-time unit counts and every prescale ratio (1, 2, 4 and 8) can be reached within one elaboration. The operands the bench loads carry junk above 8N bits for N < 4, so the masking at the start of an operation and the preservation of X are both exercised. The cases also cover a divide whose high half equals the divisor, a zero divisor, operation codes 00 and 11, and junk loads made during a running operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_MUL  = 2'b01,
    OP_DIV  = 2'b10,
    OP_BAD  = 2'b11
  } op_e;

  // Control word field positions
  localparam int CW_OP_LO   = 0;
  localparam int CW_CLR_Z   = 2;
  localparam int CW_CLR_Y   = 3;
  localparam int CW_UNIT_LO = 4;
  localparam int CW_PRESC   = 7;

  // Unit code 11->1, 10->2, 01->3, 00->4, capped at the built maximum
  function automatic logic [2:0] decode_units(input logic [1:0] code, input int max_u);
    logic [2:0] u;
    u = 3'd4 - {1'b0, code};
    if (int'(u) > max_u) u = 3'(max_u);
    return u;
  endfunction

  function automatic logic [3:0] prescale_ratio(input logic en, input logic [2:0] units);
    if (!en)             return 4'd1;
    else if (units == 1) return 4'd2;
    else if (units == 2) return 4'd4;
    else                 return 4'd8;
  endfunction

endpackage

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
#(
  parameter int MAX_UNITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_data,
  output logic        accept,
  output logic        start,
  output logic        step,
  output logic        busy,
  output logic        done,
  output op_e         op,
  output logic [2:0]  units
);

  localparam int PW = $clog2(8 * MAX_UNITS + 1);

  logic [7:0]    ctrl_q;
  logic [2:0]    pc;
  logic [PW-1:0] pulse;
  logic [PW-1:0] last;
  logic [3:0]    ratio;
  logic          tick;
  logic [1:0]    new_op;

  always_comb begin
    units  = decode_units(ctrl_q[CW_UNIT_LO +: 2], MAX_UNITS);
    op     = op_e'(ctrl_q[CW_OP_LO +: 2]);
    last   = PW'({units, 3'b000});
    ratio  = prescale_ratio(ctrl_q[CW_PRESC], units);
    tick   = busy && ({1'b0, pc} == (ratio - 4'd1));
    step   = tick && (pulse != '0);
    accept = ctl_we && !busy;
    new_op = ctl_data[CW_OP_LO +: 2];
    start  = accept && ((new_op == OP_MUL) || (new_op == OP_DIV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      pc     <= '0;
      pulse  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        ctrl_q <= ctl_data;
        pc     <= '0;
        pulse  <= '0;
        busy   <= start;
      end else if (busy) begin
        if (tick) begin
          pc <= '0;
          if (pulse == last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            pulse <= pulse + 1'b1;
          end
        end else begin
          pc <= pc + 3'd1;
        end
      end
    end
  end

  // R4: an illegal or empty operation code never raises busy
  p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start) |=> !busy);

  // R7: a start raises busy with the pulse count at zero
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && pulse == '0));

  // R7: done only follows a busy cycle, and lasts one cycle
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the pulse count never passes 8N
  p_pulse_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pulse <= last));

  // R8: the prescale counter stays below the ratio
  p_presc_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, pc} < ratio));

endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_x,
  input  logic                 ld_y,
  input  logic                 ld_z,
  input  logic [W-1:0]         ld_data,
  input  logic                 busy,
  input  logic                 accept,
  input  logic                 start,
  input  logic                 clr_y,
  input  logic                 clr_z,
  input  logic [W-1:0]         mask_new,
  input  logic                 step,
  input  op_e                  op,
  input  logic [W-1:0]         mask,
  input  logic [$clog2(W)-1:0] top_pos,
  output logic [W-1:0]         x_q,
  output logic [W-1:0]         y_q,
  output logic [W-1:0]         z_q,
  output logic                 ovf
);

  logic [W-1:0] xm;
  logic [W:0]   sum;
  logic [W:0]   ytmp;
  logic [W:0]   ydiff;
  logic         geq;
  logic [W-1:0] y_nx;
  logic [W-1:0] z_nx;
  logic [W-1:0] y_eff;

  always_comb begin
    xm    = x_q & mask;
    // multiply: conditional add of X, then shift Y:Z right one place
    sum   = {1'b0, y_q} + (z_q[0] ? {1'b0, xm} : '0);
    // divide: shift Y:Z left one place, subtract X when it fits
    ytmp  = {y_q, z_q[top_pos]};
    geq   = (ytmp >= {1'b0, xm});
    ydiff = ytmp - {1'b0, xm};
    if (op == OP_DIV) begin
      y_nx = (geq ? ydiff[W-1:0] : ytmp[W-1:0]) & mask;
      z_nx = {z_q[W-2:0], geq} & mask;
    end else begin
      y_nx = sum[W:1];
      z_nx = (z_q >> 1) | ({{(W-1){1'b0}}, sum[0]} << top_pos);
    end
    y_eff = clr_y ? '0 : (y_q & mask_new);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
      ovf <= 1'b0;
    end else if (accept) begin
      ovf <= (y_eff >= (x_q & mask_new));
      if (clr_y)      y_q <= '0;
      else if (start) y_q <= y_q & mask_new;
      if (clr_z)      z_q <= '0;
      else if (start) z_q <= z_q & mask_new;
    end else if (step) begin
      y_q <= y_nx;
      z_q <= z_nx;
    end else if (!busy) begin
      if (ld_x) x_q <= ld_data;
      if (ld_y) y_q <= ld_data;
      if (ld_z) z_q <= ld_data;
    end
  end

  // R9: X never moves during an operation
  p_x_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(x_q));

  // R3: the overflow flag only changes on a control write
  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ovf));

  // R5: bits above 8N stay clear while an operation runs
  p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((y_q & ~mask) == '0) && ((z_q & ~mask) == '0)));

endmodule

// File: rtl/mdu_engine.sv
module mdu_engine
  import mdu_pkg::*;
#(
  parameter int MAX_UNITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_x,
  input  logic                   ld_y,
  input  logic                   ld_z,
  input  logic [8*MAX_UNITS-1:0] ld_data,
  input  logic                   ctl_we,
  input  logic [7:0]             ctl_data,
  output logic [8*MAX_UNITS-1:0] x_q,
  output logic [8*MAX_UNITS-1:0] y_q,
  output logic [8*MAX_UNITS-1:0] z_q,
  output logic [7:0]             status,
  output logic                   busy,
  output logic                   done
);

  localparam int W  = 8 * MAX_UNITS;
  localparam int TW = $clog2(W);

  logic          accept;
  logic          start;
  logic          step;
  op_e           op;
  logic [2:0]    units;
  logic [2:0]    units_new;
  logic [W-1:0]  mask;
  logic [W-1:0]  mask_new;
  logic [TW-1:0] top_pos;
  logic          ovf;

  always_comb begin
    units_new = decode_units(ctl_data[CW_UNIT_LO +: 2], MAX_UNITS);
    mask_new  = {W{1'b1}} >> (W - 8 * int'(units_new));
    mask      = {W{1'b1}} >> (W - 8 * int'(units));
    top_pos   = TW'(8 * int'(units) - 1);
    status    = {7'b0, ovf};
  end

  mdu_seq #(.MAX_UNITS(MAX_UNITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_data (ctl_data),
    .accept   (accept),
    .start    (start),
    .step     (step),
    .busy     (busy),
    .done     (done),
    .op       (op),
    .units    (units)
  );

  mdu_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_x     (ld_x),
    .ld_y     (ld_y),
    .ld_z     (ld_z),
    .ld_data  (ld_data),
    .busy     (busy),
    .accept   (accept),
    .start    (start),
    .clr_y    (ctl_data[CW_CLR_Y]),
    .clr_z    (ctl_data[CW_CLR_Z]),
    .mask_new (mask_new),
    .step     (step),
    .op       (op),
    .mask     (mask),
    .top_pos  (top_pos),
    .x_q      (x_q),
    .y_q      (y_q),
    .z_q      (z_q),
    .ovf      (ovf)
  );

  // R10: the engine is idle and clean right after a clear
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && status == 8'h00));

endmodule

// File: tb/mdu_engine_test.sv
module mdu_engine_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_x = 1'b0, ld_y = 1'b0, ld_z = 1'b0;
  logic [W-1:0] ld_data = '0;
  logic         ctl_we = 1'b0;
  logic [7:0]   ctl_data = '0;
  logic [W-1:0] x_q, y_q, z_q;
  logic [7:0]   status;
  logic         busy, done;

  int nchecks = 0;
  int nfail = 0;
  int ops_seen = 0;
  int ops_sent = 0;
  bit finished = 1'b0;

  // scoreboard queues
  logic [63:0] eq_x[$], eq_y[$], eq_z[$], eq_cyc[$];
  bit          eq_ovf[$], eq_chk[$];
  string       eq_tag[$];

  always #5 clk = ~clk;

  mdu_engine #(.MAX_UNITS(4)) uut (
    .clk(clk), .rst_n(rst_n), .ld_x(ld_x), .ld_y(ld_y), .ld_z(ld_z),
    .ld_data(ld_data), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .x_q(x_q), .y_q(y_q), .z_q(z_q), .status(status), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cword(input bit pre, input int n, input bit cy, input bit cz, input logic [1:0] op);
    logic [1:0] code;
    code = 2'(4 - n);
    return {pre, 1'b0, code, cy, cz, op};
  endfunction

  task automatic load(input int which, input logic [W-1:0] v);
    @(negedge clk);
    ld_data = v;
    ld_x = (which == 0);
    ld_y = (which == 1);
    ld_z = (which == 2);
    @(negedge clk);
    ld_x = 1'b0; ld_y = 1'b0; ld_z = 1'b0;
  endtask

  // driver: loads operands, pushes the expected item, writes the control word
  task automatic run_op(input int n, input bit pre, input logic [1:0] op, input bit cy, input bit cz,
                        input logic [W-1:0] x, input logic [W-1:0] y, input logic [W-1:0] z,
                        input bit junk, input string tag);
    logic [63:0] m, xm, ym, zm, p, dvd, r;
    bit ov;
    load(0, x); load(1, y); load(2, z);
    m  = (64'h1 << (8 * n)) - 64'h1;
    xm = {32'h0, x} & m;
    ym = cy ? 64'h0 : ({32'h0, y} & m);
    zm = cz ? 64'h0 : ({32'h0, z} & m);
    ov = (ym >= xm);
    r  = pre ? ((n == 1) ? 64'd2 : (n == 2) ? 64'd4 : 64'd8) : 64'd1;
    eq_x.push_back({32'h0, x});
    eq_ovf.push_back(ov);
    eq_cyc.push_back(64'(8 * n + 1) * r);
    eq_tag.push_back(tag);
    if (op == 2'b01) begin
      p = xm * zm + ym;
      eq_y.push_back((p >> (8 * n)) & m);
      eq_z.push_back(p & m);
      eq_chk.push_back(1'b1);
    end else begin
      dvd = (ym << (8 * n)) | zm;
      eq_y.push_back(ov ? 64'h0 : (dvd % xm));
      eq_z.push_back(ov ? 64'h0 : (dvd / xm));
      eq_chk.push_back(!ov);
    end
    @(negedge clk);
    ctl_data = cword(pre, n, cy, cz, op);
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    ops_sent++;
    if (junk) begin
      // R9: loads and a control write during the run must be ignored
      ld_x = 1'b1; ld_y = 1'b1; ld_z = 1'b1; ld_data = 32'h5A5A_A5A5;
      ctl_we = 1'b1; ctl_data = cword(1'b0, 1, 1'b1, 1'b1, 2'b01);
      @(negedge clk);
      ld_x = 1'b0; ld_y = 1'b0; ld_z = 1'b0; ctl_we = 1'b0;
    end
    while (ops_seen < ops_sent) @(negedge clk);
  endtask

  // control write with op 00 or 11: nothing may start
  task automatic ctl_idle(input int n, input logic [1:0] op, input bit cy, input bit cz,
                          input logic [W-1:0] x, input logic [W-1:0] y, input logic [W-1:0] z,
                          input string tag);
    logic [63:0] m, ym;
    bit stayed_idle;
    load(0, x); load(1, y); load(2, z);
    m  = (64'h1 << (8 * n)) - 64'h1;
    ym = cy ? 64'h0 : ({32'h0, y} & m);
    @(negedge clk);
    ctl_data = cword(1'b0, n, cy, cz, op);
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    stayed_idle = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (busy || done) stayed_idle = 1'b0;
      @(negedge clk);
    end
    chk(stayed_idle, {tag, " R4 no start"}, {63'h0, stayed_idle}, 64'h1);
    chk(status == {7'b0, (ym >= ({32'h0, x} & m))}, {tag, " R3 status"},
        {56'h0, status}, {63'h0, (ym >= ({32'h0, x} & m))});
    chk(y_q == (cy ? 32'h0 : y), {tag, " R6 Y"}, {32'h0, y_q}, {32'h0, (cy ? 32'h0 : y)});
    chk(z_q == (cz ? 32'h0 : z), {tag, " R6 Z"}, {32'h0, z_q}, {32'h0, (cz ? 32'h0 : z)});
    chk(x_q == x, {tag, " R4 X"}, {32'h0, x_q}, {32'h0, x});
  endtask

  // monitor: counts busy cycles and compares each completion with the scoreboard
  initial begin
    int  bcnt;
    bit  prev_done;
    bcnt = 0;
    prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy) bcnt++;
        if (done) begin
          chk(!prev_done, "R7 done single pulse", 64'h1, 64'h0);
          chk(!busy, "R7 busy low with done", {63'h0, busy}, 64'h0);
          if (eq_tag.size() == 0) begin
            chk(1'b0, "R7 unexpected done", 64'h1, 64'h0);
          end else begin
            string       t;
            logic [63:0] ex, ey, ez, ec;
            bit          eo, ek;
            t = eq_tag.pop_front();
            ex = eq_x.pop_front(); ey = eq_y.pop_front(); ez = eq_z.pop_front();
            ec = eq_cyc.pop_front(); eo = eq_ovf.pop_front(); ek = eq_chk.pop_front();
            chk({32'h0, x_q} == ex, {t, " X kept"}, {32'h0, x_q}, ex);
            if (ek) begin
              chk({32'h0, y_q} == ey, {t, " Y"}, {32'h0, y_q}, ey);
              chk({32'h0, z_q} == ez, {t, " Z"}, {32'h0, z_q}, ez);
            end
            chk(status == {7'b0, eo}, {t, " R3 status"}, {56'h0, status}, {63'h0, eo});
            chk(64'(bcnt) == ec, {t, " R7 R8 busy cycles"}, 64'(bcnt), ec);
          end
          bcnt = 0;
          ops_seen++;
        end
        prev_done = done;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done, "R10 idle after reset", {62'h0, busy, done}, 64'h0);
    chk(status == 8'h00, "R10 status", {56'h0, status}, 64'h0);
    chk(x_q == 0 && y_q == 0 && z_q == 0, "R10 registers", {32'h0, x_q | y_q | z_q}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R5: N=1, junk above 8 bits, maximal operands
    run_op(1, 1'b0, 2'b01, 1'b0, 1'b0, 32'h1234_56FF, 32'hAB00_00FF, 32'h0000_01FF, 1'b0, "R1 R5 mul N1");
    // R1 R8: N=4 with prescale /8
    run_op(4, 1'b1, 2'b01, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D, 1'b0, "R1 R8 mul N4");
    // R2 R8: N=2 divide with prescale /4
    run_op(2, 1'b1, 2'b10, 1'b0, 1'b0, 32'hFFFF_03B4, 32'h0000_01BF, 32'h7777_1234, 1'b0, "R2 R8 div N2");
    // R1 R6: N=3 multiply with Y cleared, prescale /8
    run_op(3, 1'b1, 2'b01, 1'b1, 1'b0, 32'h00AB_CDEF, 32'h0055_5555, 32'h00FE_DCBA, 1'b0, "R1 R6 mul N3");
    // R3: divide with high half equal to the divisor
    run_op(1, 1'b0, 2'b10, 1'b0, 1'b0, 32'h0000_0050, 32'h0000_0050, 32'h0000_0011, 1'b0, "R3 div equal N1");
    // R3: divide by zero
    run_op(2, 1'b0, 2'b10, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 1'b0, "R3 div zero N2");
    // R2 R9: N=4 divide with junk writes during the run
    run_op(4, 1'b0, 2'b10, 1'b0, 1'b0, 32'h8000_0001, 32'h0000_1234, 32'hFFFF_FFFF, 1'b1, "R2 R9 div N4");
    // R2 R6: N=3 divide with Z cleared
    run_op(3, 1'b0, 2'b10, 1'b0, 1'b1, 32'h0000_0300, 32'h0000_0100, 32'h00FF_FFFF, 1'b0, "R2 R6 div N3");
    // R1 R8: N=1 multiply, prescale /2
    run_op(1, 1'b1, 2'b01, 1'b0, 1'b0, 32'h0000_00C3, 32'h0000_0007, 32'h0000_005A, 1'b0, "R1 R8 mul N1 pre");
    // R1 R9: N=2 multiply with junk writes
    run_op(2, 1'b0, 2'b01, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_FFFF, 1'b1, "R1 R9 mul N2");
    // R4 R6 R3: op none with Z clear, Y >= X
    ctl_idle(2, 2'b00, 1'b0, 1'b1, 32'h0000_0010, 32'h0000_0020, 32'h0000_0033, "op none");
    // R4 R3: illegal op, Y < X
    ctl_idle(1, 2'b11, 1'b0, 1'b0, 32'h0000_0080, 32'h0000_0001, 32'h0000_0044, "op illegal");

    repeat (3) @(negedge clk);
    chk(eq_tag.size() == 0, "R7 all operations completed", 64'(eq_tag.size()), 64'h0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule